// File: doc/BRIEF.md
# Staggered Channel Turn-On Sequencer

This block sits between the latched channel data of a multi-group output driver and its drive enables. The channels form colour groups (red, green, blue). Each group has its own active-low enable. When a group's enable is asserted, the group's channels do not all start at once. They come on one position at a time, in rising position order, and each new position waits for one pulse of a delay-step strobe. This spreads the switching events over several step units.

The same position in every group uses the same delay. The delay always counts from that group's own enable assertion. A mode input turns the stagger off, so that every channel of an enabled group follows its data at once. The mode input is low after a configuration reset, which means staggering is the normal behaviour. Turn-off is never staggered.

Top module: `stagger_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all 24 drive enables are 0.
- R2: Bit layout. Drive enable bit g*8+(k-1) is position k (1..8) of group g. The same bit index is used for the data. Group 0 is red, group 1 is green and group 2 is blue. Each group g is controlled by enable bit g, which is active low.
- R3: In staggered mode (mode input 0), position 1 of a group turns on in the cycle after the clock edge that first samples its enable low. Position k turns on after k-1 step pulses have been sampled on later edges while the enable stays low.
- R4: Positions with the same number in different groups get the same delay when their enables are asserted on the same edge.
- R5: With the mode input at 1, every channel of an enabled group whose data is 1 is on in the cycle after the enable is sampled low.
- R6: When a group's enable is sampled high, all of that group's channels are off in the next cycle, whatever position the sequence had reached.
- R7: A new assertion of the enable (high, then low) restarts the sequence, so only position 1 is unlocked.
- R8: A channel is on only while its data bit is 1. Unlocked channels whose data is 0 stay off.
- R9: After seven step pulses all eight positions are unlocked. Further pulses change nothing.
- R10: A step pulse sampled on the same edge as the enable assertion, or while the enable is high, does not advance the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_data | input | 24 | Latched on/off data per channel (layout as in R2) |
| grp_oe_n | input | 3 | Per-group enable, active low |
| step_tick | input | 1 | Delay-step strobe; one pulse is one delay unit |
| sync_mode | input | 1 | 1: simultaneous switching; 0: staggered |
| drive_en | output | 24 | Gated drive enables |

## Verification
The in-module assertions check the following on every cycle:
- the sequence counter restarts after an enable assertion;
- a group is dark after its enable is seen high;
- no channel is on without data;
- in staggered mode only the unlocked prefix of positions can be on;
- the counter never skips a step.

The bench scenarios cover what the assertions cannot show:
- the exact cycle in which each position appears;
- equal delays across groups;
- saturation after seven pulses;
- a pulse arriving on the assertion edge being ignored.

// File: rtl/stagger_pkg.sv
package stagger_pkg;

  // Unlocked-position mask: bit p is set when p <= cnt (position 1 is p = 0).
  function automatic logic [63:0] unlock_mask(input int unsigned cnt, input int unsigned npos);
    logic [63:0] m;
    m = '0;
    for (int p = 0; p < 64; p++) begin
      if (p < npos && p <= cnt) m[p] = 1'b1;
    end
    return m;
  endfunction

  // Next counter value: saturating increment.
  function automatic int unsigned step_next(input int unsigned cnt, input int unsigned npos);
    return (cnt + 1 < npos) ? cnt + 1 : cnt;
  endfunction

endpackage

// File: rtl/stagger_grp.sv
module stagger_grp
  import stagger_pkg::*;
#(
  parameter int POS = 8,
  localparam int CW = (POS > 1) ? $clog2(POS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [POS-1:0] data_i,
  input  logic           oe_n_i,
  input  logic           tick_i,
  input  logic           sync_i,
  output logic [POS-1:0] grp_en_o
);

  localparam logic [CW-1:0] CNT_MAX = CW'(POS - 1);

  logic          oe_low_q;
  logic [CW-1:0] cnt_q;
  logic          fall_evt;   // enable newly asserted this cycle
  logic          adv_evt;    // step accepted this cycle
  logic [POS-1:0] unlock;

  assign fall_evt = !oe_n_i && !oe_low_q;
  assign adv_evt  = !oe_n_i && oe_low_q && tick_i && (cnt_q != CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_low_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      oe_low_q <= !oe_n_i;
      if (oe_n_i || fall_evt) cnt_q <= '0;
      else if (adv_evt)       cnt_q <= CW'(step_next(int'(cnt_q), POS));
    end
  end

  assign unlock   = POS'(unlock_mask(int'(cnt_q), POS));
  assign grp_en_o = {POS{oe_low_q}} & data_i & (sync_i ? {POS{1'b1}} : unlock);

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> (cnt_q == '0)); // R7

  AST_OFF_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |=> (grp_en_o == '0)); // R6

  AST_DATA_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_en_o & ~data_i) == '0); // R8

  AST_PREFIX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |-> ((grp_en_o & ~unlock) == '0)); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + CW'(1))); // R9

endmodule

// File: rtl/stagger_seq.sv
module stagger_seq
#(
  parameter int GROUPS = 3,
  parameter int POS    = 8,
  localparam int NCH   = GROUPS * POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_data,
  input  logic [GROUPS-1:0] grp_oe_n,
  input  logic              step_tick,
  input  logic              sync_mode,
  output logic [NCH-1:0]    drive_en
);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    stagger_grp #(.POS(POS)) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_i   (chan_data[g*POS +: POS]),
      .oe_n_i   (grp_oe_n[g]),
      .tick_i   (step_tick),
      .sync_i   (sync_mode),
      .grp_en_o (drive_en[g*POS +: POS])
    );
  end

  AST_RESET_DARK: assert property (@(posedge clk)
    !rst_n |=> (drive_en == '0)); // R1

endmodule

// File: tb/stagger_seq_bench.sv
`timescale 1ns/1ps
module stagger_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] chan_data = '0;
  logic [2:0]  grp_oe_n = 3'b111;
  logic        step_tick = 1'b0;
  logic        sync_mode = 1'b0;
  logic [23:0] drive_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  int m_cnt [3];
  bit m_low [3];

  stagger_seq u_stagger_seq (
    .clk(clk), .rst_n(rst_n), .chan_data(chan_data), .grp_oe_n(grp_oe_n),
    .step_tick(step_tick), .sync_mode(sync_mode), .drive_en(drive_en)
  );

  always #5 clk = ~clk;

  function automatic logic [23:0] model_out();
    logic [23:0] e;
    e = '0;
    for (int g = 0; g < 3; g++)
      for (int p = 0; p < 8; p++)
        if (m_low[g] && chan_data[g*8+p] && (sync_mode || p <= m_cnt[g])) e[g*8+p] = 1'b1;
    return e;
  endfunction

  // Reference model, updated at each edge; compared 2 ns later
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < 3; g++) begin m_cnt[g] = 0; m_low[g] = 0; end
    end else begin
      for (int g = 0; g < 3; g++) begin
        if (grp_oe_n[g]) begin
          m_low[g] = 0; m_cnt[g] = 0;
        end else begin
          if (!m_low[g]) m_cnt[g] = 0;
          else if (step_tick && m_cnt[g] < 7) m_cnt[g]++;
          m_low[g] = 1;
        end
      end
    end
    #2;
    if (rst_n && !done) begin
      checks++;
      if (drive_en !== model_out()) begin
        errors++;
        $display("FAIL R2/R3 model compare: actual %h expected %h", drive_en, model_out());
      end
    end
  end

  task automatic chk(input string req, input logic [23:0] exp);
    checks++;
    if (drive_en !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, drive_en, exp);
    end
  endtask

  task automatic cyc(input bit t);
    step_tick = t;
    @(posedge clk); #3;
    step_tick = 1'b0;
  endtask

  task automatic idle_all();
    grp_oe_n = 3'b111;
    cyc(0); cyc(0);
  endtask

  initial begin
    chan_data = 24'hFFFFFF;
    repeat (3) @(posedge clk);
    #3;
    chk("R1 in reset", 24'h0);
    rst_n = 1'b1;
    cyc(0);
    chk("R1 after reset", 24'h0);

    // R3: red staggered
    grp_oe_n = 3'b110; cyc(0);
    chk("R3 position1", 24'h000001);
    cyc(1); chk("R3 position2", 24'h000003);
    cyc(0); chk("R3 hold without tick", 24'h000003);
    cyc(1); cyc(1); chk("R3 position4", 24'h00000F);
    // R6
    grp_oe_n = 3'b111; cyc(0); chk("R6 off at once", 24'h0);

    // R10: tick on assertion edge and while disabled ignored
    cyc(1); chk("R10 tick while high", 24'h0);
    grp_oe_n = 3'b110; cyc(1); chk("R10 tick on fall", 24'h000001);
    // R9 saturation
    for (int i = 0; i < 10; i++) cyc(1);
    chk("R9 saturated", 24'h0000FF);
    // R7 restart
    grp_oe_n = 3'b111; cyc(0);
    grp_oe_n = 3'b110; cyc(0); chk("R7 restart", 24'h000001);
    idle_all();

    // R4: all groups together
    grp_oe_n = 3'b000; cyc(0); chk("R4 equal pos1", 24'h010101);
    cyc(1); chk("R4 equal pos2", 24'h030303);
    idle_all();

    // R5: simultaneous mode, green only
    sync_mode = 1'b1;
    grp_oe_n = 3'b101; cyc(0); chk("R5 simultaneous", 24'h00FF00);
    idle_all();

    // R8: data gating
    chan_data = 24'h0000A5;
    grp_oe_n = 3'b110; cyc(0); chk("R8 sync gated", 24'h0000A5);
    idle_all();
    sync_mode = 1'b0;
    grp_oe_n = 3'b110; cyc(0); chk("R8 pos1 data1", 24'h000001);
    cyc(1); chk("R8 pos2 data0", 24'h000001);
    cyc(1); chk("R8 pos3 data1", 24'h000005);
    chan_data = 24'h0000A4; #1; chk("R8 data cleared", 24'h000004);
    idle_all();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule